// File: doc/BRIEF.md
# Bounded Downward Stack Controller

This block owns the stack pointer of a small 8-bit processor whose whole address space is 256 bytes. The stack sits in a fixed window at the top of that space, from 0xEA up to 0xFF, which gives room for 22 bytes. The execute stage sends one request per cycle. It can save a register, save a return address for a subroutine call, or restore the top byte for a register load or a subroutine return. The block drives the memory address, the write strobe and the write data for the request in the same cycle. For a restore it passes the byte read from memory back to the requester.

The stack grows downward. A save first moves the pointer down by one and then writes at the new top. A restore reads the current top and then moves the pointer up by one. Internally the pointer is nine bits wide, so the empty state (one above 0xFF) is distinct from every real address. A save into a full window is refused with an overflow error. A restore from an empty window is refused with an underflow error. A refused request leaves both memory and the pointer untouched.

Top module: `stack_ctrl`

## Requirements
- R1: After a synchronous active-low reset the stack is empty: `depth_o` is 0, `empty_o` is 1, `full_o` is 0 and `sp_o` reads 0x00.
- R2: A register save (`op_i` = 1) on a stack that is not full asserts `mem_we_o` with `mem_wdata_o` equal to `reg_data_i` in the same cycle, and `depth_o` is one higher after the clock edge.
- R3: A return-address save (`op_i` = 2) on a stack that is not full writes `pc_i + 2` modulo 256, which is the byte that follows a two-byte call.
- R4: A restore (`op_i` = 3) on a non-empty stack keeps `mem_we_o` low, asserts `pop_valid_o` with `pop_data_o` equal to `mem_rdata_i`, and `depth_o` is one lower after the clock edge.
- R5: A save while 22 bytes are held asserts `err_overflow_o` and keeps `mem_we_o` low, and `depth_o` and `sp_o` are unchanged afterwards.
- R6: A restore while empty asserts `err_underflow_o` and keeps `pop_valid_o` low, and the stack stays empty.
- R7: An idle request (`op_i` = 0) writes nothing, raises no error and leaves depth and pointer unchanged.
- R8: Bytes are restored in the reverse order in which they were saved.
- R9: A save with n bytes already held writes at address 0xFF − n, and a restore with n bytes held reads at 0x100 − n. Every access therefore falls within 0xEA..0xFF.
- R10: When the stack is not empty, `sp_o` is the address of the top byte (0x100 − depth). `full_o` is high exactly when 22 bytes are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_i | input | 2 | Request: 0 idle, 1 save register, 2 save return address, 3 restore |
| reg_data_i | input | 8 | Register value to save |
| pc_i | input | 8 | Address of the call instruction |
| mem_rdata_i | input | 8 | Byte read from memory at `mem_addr_o` |
| mem_addr_o | output | 8 | Memory address of the current access |
| mem_we_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 8 | Byte to write |
| pop_data_o | output | 8 | Restored byte |
| pop_valid_o | output | 1 | Restore performed this cycle |
| err_overflow_o | output | 1 | Save refused, stack full |
| err_underflow_o | output | 1 | Restore refused, stack empty |
| sp_o | output | 8 | Stack pointer, low byte |
| depth_o | output | 5 | Bytes currently held |
| empty_o | output | 1 | No bytes held |
| full_o | output | 1 | Window full |

## Verification
The hardest state to reach is the full window, because overflow needs 22 net saves with no restore in between. A random mix of saves and restores drifts around the middle and seldom gets there. The stimulus therefore runs in alternating phases, one weighted toward saves and one weighted toward restores, so the random run keeps hitting both full and empty. Directed sequences add an exact fill to 22 followed by refused saves, a full drain followed by refused restores, and a return-address save with a program counter near 0xFF to show the wrap.

// File: rtl/stack_pkg.sv
// Shared types for the stack controller.
// Assumes the requester presents at most one request per cycle.
package stack_pkg;
    typedef enum logic [1:0] {
        OP_IDLE     = 2'd0,
        OP_PUSH_REG = 2'd1,
        OP_PUSH_RET = 2'd2,
        OP_POP      = 2'd3
    } stack_op_e;
endpackage

// File: rtl/stack_guard.sv
// Request qualifier: turns a request into a permitted save or restore,
// or into an overflow or underflow error. Purely combinational.
// Assumes full/empty come from the pointer register of the same cycle.
module stack_guard
    import stack_pkg::*;
(
    input  stack_op_e op,
    input  logic      full,
    input  logic      empty,
    output logic      do_push,
    output logic      do_pop,
    output logic      err_ovf,
    output logic      err_unf
);
    logic is_push;
    logic is_pop;

    // Classify the request and gate it on the window bounds
    always_comb begin
        is_push = (op == OP_PUSH_REG) || (op == OP_PUSH_RET);
        is_pop  = (op == OP_POP);
        do_push = is_push && !full;
        do_pop  = is_pop && !empty;
        err_ovf = is_push && full;
        err_unf = is_pop && empty;
    end
endmodule

// File: rtl/stack_ptr.sv
// Downward-growing stack pointer kept one bit wider than the address,
// so that "empty" (one past TOP) differs from every real address.
// Assumes do_push and do_pop are already qualified and never both high.
module stack_ptr #(
    parameter int DATA_W = 8,
    parameter int BASE   = 'hEA,
    parameter int TOP    = 'hFF,
    parameter int DEPTH_W = $clog2(TOP - BASE + 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               do_push,
    input  logic               do_pop,
    output logic [DATA_W-1:0]  sp_lo,
    output logic [DEPTH_W-1:0] depth,
    output logic               empty,
    output logic               full
);
    localparam int PTR_W    = DATA_W + 1;
    localparam int CAPACITY = TOP - BASE + 1;
    localparam logic [PTR_W-1:0] EMPTY_V = PTR_W'(TOP + 1);
    localparam logic [PTR_W-1:0] FULL_V  = PTR_W'(BASE);

    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] used;

    // Pointer register: down on save, up on restore
    always_ff @(posedge clk) begin
        if (!rst_n)       ptr_q <= EMPTY_V;
        else if (do_push) ptr_q <= ptr_q - PTR_W'(1);
        else if (do_pop)  ptr_q <= ptr_q + PTR_W'(1);
    end

    // Derived occupancy and bound flags
    always_comb begin
        used  = EMPTY_V - ptr_q;
        depth = used[DEPTH_W-1:0];
        empty = (ptr_q == EMPTY_V);
        full  = (ptr_q == FULL_V);
        sp_lo = ptr_q[DATA_W-1:0];
    end

    assert_depth_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(depth) <= CAPACITY);
    assert_push_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        do_push |=> depth == $past(depth) + DEPTH_W'(1));
    assert_pop_shrinks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        do_pop |=> depth == $past(depth) - DEPTH_W'(1));
    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!do_push && !do_pop) |=> $stable(sp_lo));
endmodule

// File: rtl/stack_port.sv
// Memory-side driver: picks the access address, write strobe and write
// data for a qualified request and forwards the read byte on a restore.
// Assumes memory read data is valid in the cycle the address is driven.
module stack_port
    import stack_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int RET_OFFSET = 2
) (
    input  stack_op_e          op,
    input  logic               do_push,
    input  logic               do_pop,
    input  logic [DATA_W-1:0]  sp_lo,
    input  logic [DATA_W-1:0]  reg_data,
    input  logic [DATA_W-1:0]  pc,
    input  logic [DATA_W-1:0]  rdata,
    output logic [DATA_W-1:0]  addr,
    output logic               we,
    output logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  pop_data,
    output logic               pop_valid
);
    logic [DATA_W-1:0] ret_addr;

    generate
        if (RET_OFFSET == 0) begin : g_ret_direct
            assign ret_addr = pc;
        end else begin : g_ret_offset
            assign ret_addr = pc + DATA_W'(RET_OFFSET);
        end
    endgenerate

    // Address, strobe and data selection
    always_comb begin
        addr      = do_push ? (sp_lo - DATA_W'(1)) : sp_lo;
        we        = do_push;
        wdata     = (op == OP_PUSH_RET) ? ret_addr : reg_data;
        pop_valid = do_pop;
        pop_data  = do_pop ? rdata : '0;
    end
endmodule

// File: rtl/stack_ctrl.sv
// Bounded stack controller: a 22-byte downward stack at the top of a
// 256-byte space, with refused accesses reported as overflow/underflow.
// Assumes an external memory with combinational read and clocked write.
module stack_ctrl
    import stack_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int BASE       = 'hEA,
    parameter int TOP        = 'hFF,
    parameter int RET_OFFSET = 2,
    localparam int DEPTH_W   = $clog2(TOP - BASE + 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         op_i,
    input  logic [DATA_W-1:0]  reg_data_i,
    input  logic [DATA_W-1:0]  pc_i,
    input  logic [DATA_W-1:0]  mem_rdata_i,
    output logic [DATA_W-1:0]  mem_addr_o,
    output logic               mem_we_o,
    output logic [DATA_W-1:0]  mem_wdata_o,
    output logic [DATA_W-1:0]  pop_data_o,
    output logic               pop_valid_o,
    output logic               err_overflow_o,
    output logic               err_underflow_o,
    output logic [DATA_W-1:0]  sp_o,
    output logic [DEPTH_W-1:0] depth_o,
    output logic               empty_o,
    output logic               full_o
);
    localparam logic [DATA_W-1:0] BASE_A = DATA_W'(BASE);

    stack_op_e op;
    logic      do_push;
    logic      do_pop;
    logic      full;
    logic      empty;

    assign op      = stack_op_e'(op_i);
    assign full_o  = full;
    assign empty_o = empty;

    stack_guard u_guard (
        .op      (op),
        .full    (full),
        .empty   (empty),
        .do_push (do_push),
        .do_pop  (do_pop),
        .err_ovf (err_overflow_o),
        .err_unf (err_underflow_o)
    );

    stack_ptr #(.DATA_W(DATA_W), .BASE(BASE), .TOP(TOP), .DEPTH_W(DEPTH_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .do_push (do_push),
        .do_pop  (do_pop),
        .sp_lo   (sp_o),
        .depth   (depth_o),
        .empty   (empty),
        .full    (full)
    );

    stack_port #(.DATA_W(DATA_W), .RET_OFFSET(RET_OFFSET)) u_port (
        .op        (op),
        .do_push   (do_push),
        .do_pop    (do_pop),
        .sp_lo     (sp_o),
        .reg_data  (reg_data_i),
        .pc        (pc_i),
        .rdata     (mem_rdata_i),
        .addr      (mem_addr_o),
        .we        (mem_we_o),
        .wdata     (mem_wdata_o),
        .pop_data  (pop_data_o),
        .pop_valid (pop_valid_o)
    );

    assert_no_write_on_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err_overflow_o |-> !mem_we_o);
    assert_overflow_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err_overflow_o |=> $stable(depth_o) && full_o);
    assert_no_pop_on_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_underflow_o |-> !pop_valid_o);
    assert_underflow_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_underflow_o |=> empty_o);
    assert_write_in_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> mem_addr_o >= BASE_A);
    assert_read_in_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pop_valid_o |-> mem_addr_o >= BASE_A);
endmodule

// File: tb/stack_ctrl_test.sv
module stack_ctrl_test;
    localparam int CAP = 22;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] op_i = 2'd0;
    logic [7:0] reg_data_i = 8'h00;
    logic [7:0] pc_i = 8'h00;
    logic [7:0] mem_rdata_i;
    logic [7:0] mem_addr_o, mem_wdata_o, pop_data_o, sp_o;
    logic       mem_we_o, pop_valid_o, err_overflow_o, err_underflow_o;
    logic [4:0] depth_o;
    logic       empty_o, full_o;

    logic [7:0] mem [0:255];
    logic [7:0] model [0:CAP-1];
    int cnt = 0;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    assign mem_rdata_i = mem[mem_addr_o];
    always @(posedge clk) if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;

    stack_ctrl uut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .reg_data_i(reg_data_i),
        .pc_i(pc_i), .mem_rdata_i(mem_rdata_i), .mem_addr_o(mem_addr_o),
        .mem_we_o(mem_we_o), .mem_wdata_o(mem_wdata_o), .pop_data_o(pop_data_o),
        .pop_valid_o(pop_valid_o), .err_overflow_o(err_overflow_o),
        .err_underflow_o(err_underflow_o), .sp_o(sp_o), .depth_o(depth_o),
        .empty_o(empty_o), .full_o(full_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_sp(input int n);
        return (n == 0) ? 8'h00 : 8'((256 - n) & 255);
    endfunction

    task automatic run_op(input logic [1:0] op, input logic [7:0] d, input logic [7:0] pc);
        logic [7:0] val;
        @(negedge clk);
        op_i = op; reg_data_i = d; pc_i = pc;
        #1;
        val = (op == 2'd2) ? pc + 8'd2 : d;
        if (op == 2'd1 || op == 2'd2) begin
            if (cnt == CAP) begin
                chk(err_overflow_o == 1'b1, "R5 overflow flag", int'(err_overflow_o), 1);
                chk(mem_we_o == 1'b0, "R5 no write when full", int'(mem_we_o), 0);
            end else begin
                chk(mem_we_o == 1'b1 && err_overflow_o == 1'b0, "R2 write strobe", int'(mem_we_o), 1);
                chk(mem_addr_o == 8'(255 - cnt), "R9 save address", int'(mem_addr_o), 255 - cnt);
                chk(mem_wdata_o == val, (op == 2'd2) ? "R3 return address" : "R2 saved data",
                    int'(mem_wdata_o), int'(val));
            end
        end else if (op == 2'd3) begin
            if (cnt == 0) begin
                chk(err_underflow_o == 1'b1, "R6 underflow flag", int'(err_underflow_o), 1);
                chk(pop_valid_o == 1'b0, "R6 no restore when empty", int'(pop_valid_o), 0);
            end else begin
                chk(pop_valid_o == 1'b1 && mem_we_o == 1'b0, "R4 restore strobe", int'(pop_valid_o), 1);
                chk(mem_addr_o == 8'(256 - cnt), "R9 restore address", int'(mem_addr_o), 256 - cnt);
                chk(pop_data_o == model[cnt-1], "R8 LIFO order", int'(pop_data_o), int'(model[cnt-1]));
            end
        end else begin
            chk(!mem_we_o && !err_overflow_o && !err_underflow_o && !pop_valid_o,
                "R7 idle quiet", int'({mem_we_o, err_overflow_o, err_underflow_o, pop_valid_o}), 0);
        end
        @(posedge clk);
        #1;
        op_i = 2'd0;
        if ((op == 2'd1 || op == 2'd2) && cnt < CAP) begin
            model[cnt] = val;
            cnt++;
        end else if (op == 2'd3 && cnt > 0) begin
            cnt--;
        end
        chk(int'(depth_o) == cnt, (op == 2'd0) ? "R7 depth held" : "R2 R4 depth", int'(depth_o), cnt);
        chk(sp_o == exp_sp(cnt), "R10 pointer", int'(sp_o), int'(exp_sp(cnt)));
        chk(full_o == (cnt == CAP) && empty_o == (cnt == 0), "R10 flags",
            int'({full_o, empty_o}), int'({cnt == CAP, cnt == 0}));
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(posedge clk);
        #1;
        chk(depth_o == 5'd0 && empty_o && !full_o && sp_o == 8'h00, "R1 reset state",
            int'({depth_o, empty_o, full_o}), 2);
        @(negedge clk);
        rst_n = 1'b1;
        // Directed: underflow on empty, idle
        run_op(2'd3, 8'h00, 8'h00);
        run_op(2'd0, 8'h00, 8'h00);
        // Directed: return address wraps past 0xFF
        run_op(2'd2, 8'h00, 8'hFE);
        run_op(2'd3, 8'h00, 8'h00);
        // Directed: fill exactly, then refused saves
        for (int i = 0; i < CAP; i++) run_op(2'd1, 8'(8'h30 + i), 8'h00);
        run_op(2'd1, 8'hAA, 8'h00);
        run_op(2'd2, 8'h00, 8'h40);
        run_op(2'd0, 8'h00, 8'h00);
        // Directed: drain fully, then refused restores
        for (int i = 0; i < CAP; i++) run_op(2'd3, 8'h00, 8'h00);
        run_op(2'd3, 8'h00, 8'h00);
        // Random phases biased alternately toward saves and restores
        for (int i = 0; i < 1200; i++) begin
            int r;
            int bias;
            logic [1:0] op;
            r = int'($urandom_range(0, 99));
            bias = ((i / 50) % 2 == 0) ? 75 : 25;
            if (r < 8) op = 2'd0;
            else if (r < bias) op = ($urandom_range(0, 3) == 0) ? 2'd2 : 2'd1;
            else op = 2'd3;
            run_op(op, 8'($urandom), 8'($urandom));
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule